// File: doc/BRIEF.md
# Rank-1 Refinement Gate Unit

This block produces the pre-activation vector of one recurrent-network gate without holding a dense weight matrix. The weights are given as a sequence of rank-1 factors: for each refinement iteration, a singular value, a pruned right vector and a left vector are streamed in. The unit forms the dot product of the pruned right vector with an on-chip copy of the concatenated input vector (current input followed by previous output). It narrows that sum and scales it by the singular value. It then broadcasts the scalar across a row of multipliers and adds each product into a bank of per-row accumulators. After the requested number of iterations it streams the accumulated rows out.

A time step starts with a load of the concatenated vector through a write port while the unit is idle. A start pulse then gives the iteration count and clears the accumulators. The pruned right vector carries only its non-zero coefficients, the same count every iteration. Each coefficient travels with the column it multiplies. Slots of a tile beyond that count are flagged unused.

Top module: `r1g_gate_unit`

## Requirements
- R1: After reset the unit is idle: `sig_ready`, `rf_ready`, `lf_ready` and `pre_valid` are all 0.
- R2: A write on `xh_we` while idle stores `xh_wdata` at element `xh_addr` of the input vector. The stored vector is reused by every iteration and every later time step until rewritten. Writes made while the unit is busy are ignored.
- R3: `step_go` while idle latches an iteration count equal to `step_iters`, with 0 taken as 1 and values above MAX_STEPS taken as MAX_STEPS. Exactly that many iterations are consumed before output begins.
- R4: Each iteration accepts one singular value, then ceil(NZ/TC) right tiles, then R/TR left tiles, with only the stream in turn showing ready. A right tile holds TC slots, and slot s occupies bits [16s+15:16s] of `rf_coef` and bits [CW*s+CW-1:CW*s] of `rf_col`. A slot with `rf_slot_en` bit s set adds coef × x[col] to the dot sum. A slot with the bit clear adds zero, whatever its data.
- R5: All values are signed Q8.8. The dot sum is kept with at least 32 bits. It is then narrowed to Q8.8 by an arithmetic right shift of 8 and saturation to [-32768, 32767].
- R6: The scalar is the product of the singular value and the narrowed dot sum, narrowed the same way.
- R7: Left tile k, lane l (bits [16l+15:16l] of `lf_data`) adds scalar × left to accumulator row k·TR+l. The accumulators sum over all iterations of a time step and are cleared by the accepted `step_go`.
- R8: After the last iteration the unit sends R/TR output tiles in row order. Lane l of tile k carries row k·TR+l, narrowed like R5. `pre_last` is set on the final tile only, after which the unit returns to idle.
- R9: While `pre_valid` is high and `pre_ready` is low, `pre_data` and `pre_last` hold steady.
- R10: `step_go` while busy is ignored: it neither clears the accumulators nor changes the iteration count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_go | input | 1 | Start of a time step (accepted while idle) |
| step_iters | input | SW | Requested refinement iteration count |
| xh_we | input | 1 | Input-vector element write strobe |
| xh_addr | input | CW | Input-vector element index |
| xh_wdata | input | 16 | Input-vector element, Q8.8 |
| sig_valid | input | 1 | Singular value valid |
| sig_ready | output | 1 | Singular value accepted |
| sig_data | input | 16 | Singular value, Q8.8 |
| rf_valid | input | 1 | Right-vector tile valid |
| rf_ready | output | 1 | Right-vector tile accepted |
| rf_coef | input | TC*16 | Non-zero right coefficients, Q8.8 |
| rf_col | input | TC*CW | Column index per slot |
| rf_slot_en | input | TC | Slot-used flags |
| lf_valid | input | 1 | Left-vector tile valid |
| lf_ready | output | 1 | Left-vector tile accepted |
| lf_data | input | TR*16 | Left-vector elements, Q8.8 |
| pre_valid | output | 1 | Output tile valid |
| pre_ready | input | 1 | Output tile accepted |
| pre_data | output | TR*16 | Pre-activation rows, Q8.8 |
| pre_last | output | 1 | Final output tile |

## Verification
The assertions take for granted that every column index in a used slot is below C and that the accumulators never exceed their width within MAX_STEPS iterations. With 16-bit operands and a 40-bit bank that holds. They also assume nothing upstream depends on `step_go` being taken while busy. The stimulus draws column indices modulo C and keeps amplitudes inside 16 bits. It uses at most MAX_STEPS iterations, so the bank never wraps even in the saturating case. Busy-time writes and start pulses are applied only while the unit waits for a right tile.

// File: rtl/r1g_pkg.sv
// Shared types and arithmetic helpers for the rank-1 gate unit.
// Assumes all data values are signed Q8.8 in 16 bits.
package r1g_pkg;

    localparam int DW = 16;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SIGMA = 3'd1,
        ST_DOT   = 3'd2,
        ST_SCALE = 3'd3,
        ST_LEFT  = 3'd4,
        ST_OUT   = 3'd5
    } r1g_state_t;

    // Narrow a Q.16 value to Q8.8: floor shift by 8, then saturate.
    function automatic logic signed [DW-1:0] sat_narrow(input logic signed [63:0] v);
        logic signed [63:0] s;
        s = v >>> 8;
        if (s > 64'sd32767)       return 16'sh7fff;
        else if (s < -64'sd32768) return 16'sh8000;
        else                      return s[DW-1:0];
    endfunction

endpackage

// File: rtl/r1g_vec_store.sv
// Holds the concatenated input vector (current input then previous output).
// One element is written per cycle when wr_en is set; TC lanes read it
// combinationally by column index. Assumes every read index is below C.
module r1g_vec_store #(
    parameter int C  = 8,
    parameter int TC = 2,
    localparam int CW = (C > 1) ? $clog2(C) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CW-1:0]        wr_idx,
    input  logic [15:0]          wr_data,
    input  logic [TC*CW-1:0]     rd_idx,
    output logic [TC*16-1:0]     rd_data
);
    logic [15:0] x_q [C];

    // Element storage, cleared at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < C; i++) x_q[i] <= '0;
        end else if (wr_en) begin
            x_q[wr_idx] <= wr_data;
        end
    end

    // One read port per dot-product lane.
    for (genvar l = 0; l < TC; l++) begin : g_rd
        assign rd_data[l*16 +: 16] = x_q[rd_idx[l*CW +: CW]];
    end

endmodule

// File: rtl/r1g_dot.sv
// Tiled dot-product engine: TC multipliers sum the used slots of one
// right-vector tile per cycle into a wide accumulator. The accumulated
// value is presented narrowed to Q8.8 with saturation.
// Assumes ACC_W > 32 and that clr and tile_en never coincide.
module r1g_dot
    import r1g_pkg::*;
#(
    parameter int TC    = 2,
    parameter int ACC_W = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 tile_en,
    input  logic [TC*16-1:0]     coef,
    input  logic [TC-1:0]        slot_en,
    input  logic [TC*16-1:0]     xval,
    output logic signed [15:0]   dot_q
);
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] tile_sum;
    logic signed [31:0]      prod [TC];

    // Lane multipliers; an unused slot yields zero.
    for (genvar l = 0; l < TC; l++) begin : g_mul
        always_comb begin
            if (slot_en[l])
                prod[l] = $signed(coef[l*16 +: 16]) * $signed(xval[l*16 +: 16]);
            else
                prod[l] = '0;
        end
    end

    // Adder tree over the lanes, sign-extended to accumulator width.
    always_comb begin
        tile_sum = '0;
        for (int l = 0; l < TC; l++)
            tile_sum = tile_sum + {{(ACC_W-32){prod[l][31]}}, prod[l]};
    end

    // Running dot-product sum across tiles of one iteration.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else if (tile_en)  acc_q <= acc_q + tile_sum;
    end

    assign dot_q = sat_narrow({{(64-ACC_W){acc_q[ACC_W-1]}}, acc_q});

    // R4: a new iteration starts its dot sum from zero.
    p_dot_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));

endmodule

// File: rtl/r1g_lane_bank.sv
// Scale stage and row accumulator bank. Latches the singular value, forms
// the narrowed scalar, broadcasts it to TR lanes and accumulates each
// lane product into the row selected by the left tile index. Output rows
// are read one tile at a time, narrowed to Q8.8 with saturation.
// Assumes R is a multiple of TR and tile indices stay below R/TR.
module r1g_lane_bank
    import r1g_pkg::*;
#(
    parameter int R     = 8,
    parameter int TR    = 2,
    parameter int ACC_W = 40,
    localparam int RT   = R / TR,
    localparam int RTW  = (RT > 1) ? $clog2(RT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 sigma_we,
    input  logic [15:0]          sigma_in,
    input  logic                 scale_en,
    input  logic signed [15:0]   dot_q,
    input  logic                 acc_en,
    input  logic [RTW-1:0]       tile,
    input  logic [TR*16-1:0]     left,
    output logic [TR*16-1:0]     rows
);
    logic signed [15:0]      sigma_q;
    logic signed [15:0]      scalar_q;
    logic signed [31:0]      scale_prod;
    logic signed [ACC_W-1:0] acc_q [R];

    // Singular value register for the current iteration.
    always_ff @(posedge clk) begin
        if (!rst_n)        sigma_q <= '0;
        else if (sigma_we) sigma_q <= sigma_in;
    end

    assign scale_prod = sigma_q * dot_q;

    // Scalar register: singular value times narrowed dot, narrowed again.
    always_ff @(posedge clk) begin
        if (!rst_n)        scalar_q <= '0;
        else if (scale_en) scalar_q <= sat_narrow({{32{scale_prod[31]}}, scale_prod});
    end

    // One accumulator per output row, written when its tile is presented.
    for (genvar r = 0; r < R; r++) begin : g_row
        localparam int TILE = r / TR;
        localparam int LANE = r % TR;
        logic signed [31:0] lp;
        assign lp = scalar_q * $signed(left[LANE*16 +: 16]);
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                acc_q[r] <= '0;
            else if (acc_en && (tile == RTW'(TILE)))
                acc_q[r] <= acc_q[r] + {{(ACC_W-32){lp[31]}}, lp};
        end
    end

    // Output read port: one tile of narrowed rows.
    for (genvar l = 0; l < TR; l++) begin : g_rd
        logic signed [ACC_W-1:0] a;
        assign a = acc_q[int'(tile) * TR + l];
        assign rows[l*16 +: 16] = sat_narrow({{(64-ACC_W){a[ACC_W-1]}}, a});
    end

    // R7: the accepted start pulse leaves every row at zero.
    p_bank_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q[0] == '0) && (acc_q[R-1] == '0));

endmodule

// File: rtl/r1g_ctrl.sv
// Sequencer for one time step: idle -> (singular value -> right tiles ->
// scale -> left tiles) x iterations -> output tiles -> idle. Ready and
// valid flags depend only on state, never on the partner's valid.
// Assumes step_iters is sampled only in the cycle step_go is accepted.
module r1g_ctrl
    import r1g_pkg::*;
#(
    parameter int NZT       = 3,
    parameter int RT        = 4,
    parameter int MAX_STEPS = 4,
    parameter int SW        = 4,
    localparam int MAXT     = (NZT > RT) ? NZT : RT,
    localparam int TW       = (MAXT > 1) ? $clog2(MAXT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_go,
    input  logic [SW-1:0]    step_iters,
    input  logic             sig_valid,
    input  logic             rf_valid,
    input  logic             lf_valid,
    input  logic             pre_ready,
    output logic             idle,
    output logic             sig_ready,
    output logic             rf_ready,
    output logic             lf_ready,
    output logic             pre_valid,
    output logic             pre_last,
    output logic             clr_bank,
    output logic             clr_dot,
    output logic             dot_en,
    output logic             scale_en,
    output logic             acc_en,
    output logic [TW-1:0]    tcnt
);
    r1g_state_t        state_q;
    logic [SW-1:0]     n_q;
    logic [SW-1:0]     iter_q;
    logic [SW-1:0]     n_eff;

    // Clamp the requested iteration count to [1, MAX_STEPS].
    always_comb begin
        if (step_iters == '0)                  n_eff = SW'(1);
        else if (step_iters > SW'(MAX_STEPS))  n_eff = SW'(MAX_STEPS);
        else                                   n_eff = step_iters;
    end

    // State, tile counter and iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tcnt    <= '0;
            iter_q  <= '0;
            n_q     <= SW'(1);
        end else begin
            case (state_q)
                ST_IDLE: if (step_go) begin
                    n_q     <= n_eff;
                    iter_q  <= '0;
                    tcnt    <= '0;
                    state_q <= ST_SIGMA;
                end
                ST_SIGMA: if (sig_valid) begin
                    tcnt    <= '0;
                    state_q <= ST_DOT;
                end
                ST_DOT: if (rf_valid) begin
                    if (tcnt == TW'(NZT-1)) begin
                        tcnt    <= '0;
                        state_q <= ST_SCALE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_SCALE: begin
                    tcnt    <= '0;
                    state_q <= ST_LEFT;
                end
                ST_LEFT: if (lf_valid) begin
                    if (tcnt == TW'(RT-1)) begin
                        tcnt <= '0;
                        if (iter_q == n_q - 1'b1) begin
                            state_q <= ST_OUT;
                        end else begin
                            iter_q  <= iter_q + 1'b1;
                            state_q <= ST_SIGMA;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_OUT: if (pre_ready) begin
                    if (tcnt == TW'(RT-1)) begin
                        tcnt    <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // State-decoded handshakes and datapath strobes.
    always_comb begin
        idle      = (state_q == ST_IDLE);
        sig_ready = (state_q == ST_SIGMA);
        rf_ready  = (state_q == ST_DOT);
        lf_ready  = (state_q == ST_LEFT);
        pre_valid = (state_q == ST_OUT);
        pre_last  = pre_valid && (tcnt == TW'(RT-1));
        clr_bank  = idle && step_go;
        clr_dot   = sig_ready && sig_valid;
        dot_en    = rf_ready && rf_valid;
        scale_en  = (state_q == ST_SCALE);
        acc_en    = lf_ready && lf_valid;
    end

    // R3: while busy the latched count is clamped and the iteration in range.
    p_iter_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (n_q >= SW'(1)) && (n_q <= SW'(MAX_STEPS)) && (iter_q < n_q));

    // R10: a start pulse while busy leaves the latched count alone.
    p_busy_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && step_go) |=> $stable(n_q));

endmodule

// File: rtl/r1g_gate_unit.sv
// Top of the rank-1 refinement gate unit. Connects the input-vector store,
// the tiled dot engine, the scale/accumulate bank and the sequencer.
// Assumes NZ >= 1, R a multiple of TR, ACC_W > 32.
module r1g_gate_unit #(
    parameter int R         = 8,
    parameter int C         = 8,
    parameter int TR        = 2,
    parameter int TC        = 2,
    parameter int NZ        = 5,
    parameter int MAX_STEPS = 4,
    parameter int ACC_W     = 40,
    localparam int CW       = (C > 1) ? $clog2(C) : 1,
    localparam int SW       = $clog2(MAX_STEPS + 1) + 1,
    localparam int NZT      = (NZ + TC - 1) / TC,
    localparam int RT       = R / TR,
    localparam int RTW      = (RT > 1) ? $clog2(RT) : 1,
    localparam int MAXT     = (NZT > RT) ? NZT : RT,
    localparam int TW       = (MAXT > 1) ? $clog2(MAXT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_go,
    input  logic [SW-1:0]       step_iters,
    input  logic                xh_we,
    input  logic [CW-1:0]       xh_addr,
    input  logic [15:0]         xh_wdata,
    input  logic                sig_valid,
    output logic                sig_ready,
    input  logic [15:0]         sig_data,
    input  logic                rf_valid,
    output logic                rf_ready,
    input  logic [TC*16-1:0]    rf_coef,
    input  logic [TC*CW-1:0]    rf_col,
    input  logic [TC-1:0]       rf_slot_en,
    input  logic                lf_valid,
    output logic                lf_ready,
    input  logic [TR*16-1:0]    lf_data,
    output logic                pre_valid,
    input  logic                pre_ready,
    output logic [TR*16-1:0]    pre_data,
    output logic                pre_last
);
    logic              idle, clr_bank, clr_dot, dot_en, scale_en, acc_en;
    logic [TW-1:0]     tcnt;
    logic [TC*16-1:0]  xval;
    logic signed [15:0] dot_q;

    r1g_ctrl #(
        .NZT(NZT), .RT(RT), .MAX_STEPS(MAX_STEPS), .SW(SW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .step_go(step_go), .step_iters(step_iters),
        .sig_valid(sig_valid), .rf_valid(rf_valid), .lf_valid(lf_valid),
        .pre_ready(pre_ready),
        .idle(idle), .sig_ready(sig_ready), .rf_ready(rf_ready),
        .lf_ready(lf_ready), .pre_valid(pre_valid), .pre_last(pre_last),
        .clr_bank(clr_bank), .clr_dot(clr_dot), .dot_en(dot_en),
        .scale_en(scale_en), .acc_en(acc_en), .tcnt(tcnt)
    );

    // Writes are accepted only between time steps.
    r1g_vec_store #(.C(C), .TC(TC)) u_vec (
        .clk(clk), .rst_n(rst_n),
        .wr_en(xh_we && idle), .wr_idx(xh_addr), .wr_data(xh_wdata),
        .rd_idx(rf_col), .rd_data(xval)
    );

    r1g_dot #(.TC(TC), .ACC_W(ACC_W)) u_dot (
        .clk(clk), .rst_n(rst_n),
        .clr(clr_dot), .tile_en(dot_en),
        .coef(rf_coef), .slot_en(rf_slot_en), .xval(xval),
        .dot_q(dot_q)
    );

    r1g_lane_bank #(.R(R), .TR(TR), .ACC_W(ACC_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .clr(clr_bank),
        .sigma_we(clr_dot), .sigma_in(sig_data),
        .scale_en(scale_en), .dot_q(dot_q),
        .acc_en(acc_en), .tile(tcnt[RTW-1:0]), .left(lf_data),
        .rows(pre_data)
    );

    // R9: a stalled output tile holds its payload.
    p_pre_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_valid && !pre_ready) |=> pre_valid && $stable(pre_data) && $stable(pre_last));

    // R4: at most one stream is offered a transfer in any cycle.
    p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sig_ready, rf_ready, lf_ready, pre_valid}));

endmodule

// File: tb/r1g_gate_unit_test.sv
module r1g_gate_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int R = 8, C = 8, TR = 2, TC = 2, NZ = 5, MAX_STEPS = 4;
    localparam int CW  = 3;
    localparam int SW  = $clog2(MAX_STEPS + 1) + 1;
    localparam int NZT = (NZ + TC - 1) / TC;
    localparam int RT  = R / TR;

    typedef struct packed {
        int seed;
        int iters;
        int amp;
        int reload;
        int poke;
    } case_t;

    localparam int NCASE = 5;
    localparam case_t CASES [NCASE] = '{
        '{seed: 11, iters: 2, amp: 300,   reload: 1, poke: 0},
        '{seed: 23, iters: 4, amp: 1000,  reload: 0, poke: 0},
        '{seed: 37, iters: 0, amp: 500,   reload: 1, poke: 0},
        '{seed: 41, iters: 7, amp: 200,   reload: 1, poke: 1},
        '{seed: 59, iters: 3, amp: 32767, reload: 1, poke: 0}
    };

    logic clk = 0, rst_n = 0;
    logic step_go = 0;
    logic [SW-1:0] step_iters = '0;
    logic xh_we = 0;
    logic [CW-1:0] xh_addr = '0;
    logic [15:0] xh_wdata = '0;
    logic sig_valid = 0, sig_ready;
    logic [15:0] sig_data = '0;
    logic rf_valid = 0, rf_ready;
    logic [TC*16-1:0] rf_coef = '0;
    logic [TC*CW-1:0] rf_col = '0;
    logic [TC-1:0] rf_slot_en = '0;
    logic lf_valid = 0, lf_ready;
    logic [TR*16-1:0] lf_data = '0;
    logic pre_valid, pre_ready = 0, pre_last;
    logic [TR*16-1:0] pre_data;

    int tests = 0, fails = 0;
    bit done = 0;
    int unsigned lcg;
    longint xm [C];
    longint eacc [R];

    always #(CLK_PERIOD/2) clk = ~clk;

    r1g_gate_unit uut (
        .clk(clk), .rst_n(rst_n), .step_go(step_go), .step_iters(step_iters),
        .xh_we(xh_we), .xh_addr(xh_addr), .xh_wdata(xh_wdata),
        .sig_valid(sig_valid), .sig_ready(sig_ready), .sig_data(sig_data),
        .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_coef(rf_coef),
        .rf_col(rf_col), .rf_slot_en(rf_slot_en),
        .lf_valid(lf_valid), .lf_ready(lf_ready), .lf_data(lf_data),
        .pre_valid(pre_valid), .pre_ready(pre_ready),
        .pre_data(pre_data), .pre_last(pre_last)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint rnd(input int amp);
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return longint'((lcg >> 8) % (2 * amp + 1)) - amp;
    endfunction

    function automatic longint sat16(input longint v);
        longint s = v >>> 8;
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    function automatic longint s16(input logic [15:0] v);
        return longint'($signed(v));
    endfunction

    task automatic load_x(input int amp);
        for (int i = 0; i < C; i++) begin
            xm[i] = rnd(amp);
            xh_we = 1; xh_addr = CW'(i); xh_wdata = 16'(xm[i]);
            @(negedge clk);
        end
        xh_we = 0;
    endtask

    task automatic run_case(input case_t cs);
        int neff;
        longint sigma, dsum, dq, sc;
        neff = (cs.iters == 0) ? 1 : (cs.iters > MAX_STEPS ? MAX_STEPS : cs.iters);
        lcg = cs.seed;
        if (cs.reload != 0) load_x(cs.amp);
        for (int r = 0; r < R; r++) eacc[r] = 0;
        step_iters = SW'(cs.iters); step_go = 1;
        @(negedge clk);
        step_go = 0;
        for (int it = 0; it < neff; it++) begin
            sigma = rnd(cs.amp);
            sig_valid = 1; sig_data = 16'(sigma);
            while (!sig_ready) @(negedge clk);
            @(negedge clk);
            sig_valid = 0;
            if (cs.poke != 0 && it == 0) begin
                // R2/R10: busy-time write and start pulse must be ignored
                xh_we = 1; xh_addr = '0; xh_wdata = 16'h7fff;
                step_go = 1; step_iters = SW'(1);
                @(negedge clk);
                xh_we = 0; step_go = 0;
            end
            dsum = 0;
            for (int t = 0; t < NZT; t++) begin
                for (int s = 0; s < TC; s++) begin
                    longint v = rnd(cs.amp);
                    int ci = int'((lcg >> 4) % C);
                    rf_coef[s*16 +: 16] = 16'(v);
                    rf_col[s*CW +: CW] = CW'(ci);
                    rf_slot_en[s] = (t * TC + s) < NZ;
                    if ((t * TC + s) < NZ) dsum += v * xm[ci];
                end
                rf_valid = 1;
                while (!rf_ready) @(negedge clk);
                @(negedge clk);
                rf_valid = 0;
            end
            dq = sat16(dsum);
            sc = sat16(sigma * dq);
            for (int k = 0; k < RT; k++) begin
                for (int l = 0; l < TR; l++) begin
                    longint lv = rnd(cs.amp);
                    lf_data[l*16 +: 16] = 16'(lv);
                    eacc[k*TR + l] += sc * lv;
                end
                lf_valid = 1;
                while (!lf_ready) @(negedge clk);
                @(negedge clk);
                lf_valid = 0;
            end
        end
        // R3: output must begin exactly after the clamped count
        chk("R3", "pre_valid after last iteration", longint'(pre_valid), 1);
        chk("R3", "sig_ready after last iteration", longint'(sig_ready), 0);
        // R9: stall the first tile for two cycles
        pre_ready = 0;
        begin
            logic [TR*16-1:0] held = pre_data;
            @(negedge clk); @(negedge clk);
            chk("R9", "stalled pre_data", longint'(pre_data), longint'(held));
            chk("R9", "stalled pre_valid", longint'(pre_valid), 1);
        end
        pre_ready = 1;
        for (int k = 0; k < RT; k++) begin
            for (int l = 0; l < TR; l++)
                chk("R8", $sformatf("row %0d", k*TR + l),
                    s16(pre_data[l*16 +: 16]), sat16(eacc[k*TR + l]));
            chk("R8", "pre_last", longint'(pre_last), longint'(k == RT - 1));
            @(negedge clk);
        end
        pre_ready = 0;
        chk("R8", "idle after last tile", longint'(pre_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL R4 watchdog actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "sig_ready", longint'(sig_ready), 0);
        chk("R1", "rf_ready",  longint'(rf_ready), 0);
        chk("R1", "lf_ready",  longint'(lf_ready), 0);
        chk("R1", "pre_valid", longint'(pre_valid), 0);

        // Table walk: R2, R3, R4, R5, R6, R7, R8, R9, R10 over varied patterns
        for (int i = 0; i < NCASE; i++) run_case(CASES[i]);

        // R4: unused slots with non-zero garbage contribute nothing
        lcg = 5;
        load_x(100);
        for (int r = 0; r < R; r++) eacc[r] = 0;
        step_iters = SW'(1); step_go = 1; @(negedge clk); step_go = 0;
        sig_valid = 1; sig_data = 16'h0100;
        while (!sig_ready) @(negedge clk);
        @(negedge clk); sig_valid = 0;
        for (int t = 0; t < NZT; t++) begin
            rf_coef = {16'h7fff, 16'h0100};
            rf_col = {CW'(3), CW'(2)};
            rf_slot_en = 2'b00;
            rf_valid = 1;
            while (!rf_ready) @(negedge clk);
            @(negedge clk); rf_valid = 0;
        end
        for (int k = 0; k < RT; k++) begin
            lf_data = {16'h0100, 16'h0100};
            lf_valid = 1;
            while (!lf_ready) @(negedge clk);
            @(negedge clk); lf_valid = 0;
        end
        pre_ready = 1;
        for (int k = 0; k < RT; k++) begin
            chk("R4", "all slots disabled gives zero", longint'(pre_data), 0);
            @(negedge clk);
        end
        pre_ready = 0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule